// File: doc/BRIEF.md
# Card Host Interrupt Status Register

This block holds the event and status flags of a card host controller and turns them into a single interrupt request. Pulses from the command and data paths, error detectors and FIFO logic set sticky flags. Software reads them through a small register port and clears them by writing ones. The two data-buffer-ready flags follow a different rule. A register write never clears them. They drop only when the data buffer itself is read or written.

A separate enable register masks which flags may drive the interrupt line. The interrupt output is registered. The status word also carries a live card-clock-running bit. Software polls this bit after asking for a clock start or stop, to see when the request has taken effect.

Top module: `host_int_status`

## Requirements
- R1: Under reset (rst_n low), every flag, every enable bit and irq are 0.
- R2: A one-cycle pulse on evt_pulse[i] sets status bit i+2 at the next clock edge, and the bit stays set after the pulse ends.
- R3: A write to address 0 clears every event flag (status bits 2 to NUM_EVT+1) whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R4: If an event pulse and a write that clears the same flag arrive in the same cycle, the flag ends up set.
- R5: Status bit 0 (read buffer ready) is set by rbuf_ready. Status bit 1 (write buffer ready) is set by wbuf_ready. Writes to address 0 have no effect on either bit.
- R6: Bit 0 clears on a buf_rd strobe and bit 1 clears on a buf_wr strobe. If the ready input and the matching strobe are high in the same cycle, the bit ends up set.
- R7: The enable register at address 1 stores bits 0 to NUM_EVT+1, and bit i enables status bit i. Its bit NUM_EVT+2 and all higher bits read 0.
- R8: irq goes high one clock edge after any status bit i and enable bit i are both 1. It goes low one edge after the last such pair stops being true.
- R9: Status bit NUM_EVT+2 shows card_clk_run in the same cycle, is not sticky, and ignores register writes.
- R10: Reads from addresses 2 and 3 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 status, 1 enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |
| evt_pulse | input | NUM_EVT | Event pulses that set the write-1-to-clear flags |
| rbuf_ready | input | 1 | Sets the read-buffer-ready flag |
| wbuf_ready | input | 1 | Sets the write-buffer-ready flag |
| buf_rd | input | 1 | Data buffer read strobe; clears read-buffer-ready |
| buf_wr | input | 1 | Data buffer write strobe; clears write-buffer-ready |
| card_clk_run | input | 1 | Live card clock running state |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench drives a set pulse and a clear in the same cycle, both for an event flag with a one-write and for a buffer flag with a buffer strobe. A design where clear has priority would read 0 there. It writes ones over the buffer-ready bits and over the clock-running bit. A design that treated them as write-1-to-clear would lose a set flag, and one that latched the clock bit would report a stale value. It also times the interrupt edge by edge, so an unregistered irq or one held an extra cycle is caught.

// File: rtl/hsr_pkg.sv
package hsr_pkg;
   localparam int ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      SEL_STATUS = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_SPARE2 = 2'd2,
      SEL_SPARE3 = 2'd3
   } reg_sel_e;

   localparam int BUF_RD_BIT = 0;
   localparam int BUF_WR_BIT = 1;
   localparam int EVT_LSB    = 2;
endpackage

// File: rtl/hsr_w1c_bank.sv
module hsr_w1c_bank #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_o
);
   initial begin
      if (N < 1) $error("hsr_w1c_bank: N must be at least 1");
   end

   for (genvar g = 0; g < N; g++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= 1'b0;
         else if (set_i[g])  q <= 1'b1;
         else if (clr_i[g])  q <= 1'b0;
      end
      assign flag_o[g] = q;

      p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flag_o[g]);
      p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (set_i[g] && clr_i[g]) |=> flag_o[g]);
      p_one_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i[g] && !set_i[g]) |=> !flag_o[g]);
      p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i[g] && !set_i[g]) |=> $stable(flag_o[g]));
   end
endmodule

// File: rtl/hsr_bufrdy.sv
module hsr_bufrdy #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] set_i,
   input  logic [LANES-1:0] take_i,
   output logic [LANES-1:0] flag_o
);
   initial begin
      if (LANES < 1) $error("hsr_bufrdy: LANES must be at least 1");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         q <= 1'b0;
         else if (set_i[g])  q <= 1'b1;
         else if (take_i[g]) q <= 1'b0;
      end
      assign flag_o[g] = q;

      p_no_drop_without_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (!take_i[g]) |=> (flag_o[g] || !$past(flag_o[g])));
      p_access_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (take_i[g] && !set_i[g]) |=> !flag_o[g]);
      p_ready_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[g] |=> flag_o[g]);
   end
endmodule

// File: rtl/hsr_irq_gen.sv
module hsr_irq_gen #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] flags_i,
   input  logic [W-1:0] enables_i,
   output logic         irq_o
);
   logic [W-1:0] hit;
   logic         any_hit;

   initial begin
      if (W < 1) $error("hsr_irq_gen: W must be at least 1");
   end

   assign hit     = flags_i & enables_i;
   assign any_hit = |hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= any_hit;
   end

   p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(flags_i & enables_i)) |=> irq_o);
   p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_i & enables_i) == '0 |=> !irq_o);
endmodule

// File: rtl/host_int_status.sv
module host_int_status
   import hsr_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int NUM_EVT = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_EVT-1:0]   evt_pulse,
   input  logic                 rbuf_ready,
   input  logic                 wbuf_ready,
   input  logic                 buf_rd,
   input  logic                 buf_wr,
   input  logic                 card_clk_run,
   output logic                 irq
);
   localparam int FLAG_W  = NUM_EVT + EVT_LSB;
   localparam int CLK_BIT = FLAG_W;

   initial begin
      if (NUM_EVT < 1)           $error("host_int_status: NUM_EVT must be at least 1");
      if (CLK_BIT + 1 > DATA_W)  $error("host_int_status: DATA_W too narrow for the flags");
   end

   logic                 wr_status, wr_enable;
   logic [NUM_EVT-1:0]   evt_clr, evt_flags;
   logic [1:0]           buf_flags;
   logic [FLAG_W-1:0]    flags, enable_q;
   logic [DATA_W-1:0]    status_word;
   logic                 unused_wdata_hi;

   assign wr_status       = reg_wr && (reg_addr == SEL_STATUS);
   assign wr_enable       = reg_wr && (reg_addr == SEL_ENABLE);
   assign evt_clr         = wr_status ? reg_wdata[FLAG_W-1:EVT_LSB] : '0;
   assign unused_wdata_hi = ^reg_wdata[DATA_W-1:FLAG_W];

   hsr_w1c_bank #(.N(NUM_EVT)) u_events (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (evt_pulse),
      .clr_i  (evt_clr),
      .flag_o (evt_flags)
   );

   hsr_bufrdy #(.LANES(2)) u_bufrdy (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({wbuf_ready, rbuf_ready}),
      .take_i ({buf_wr, buf_rd}),
      .flag_o (buf_flags)
   );

   assign flags = {evt_flags, buf_flags};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         enable_q <= '0;
      else if (wr_enable) enable_q <= reg_wdata[FLAG_W-1:0];
   end

   hsr_irq_gen #(.W(FLAG_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .flags_i   (flags),
      .enables_i (enable_q),
      .irq_o     (irq)
   );

   always_comb begin
      status_word                = '0;
      status_word[FLAG_W-1:0]    = flags;
      status_word[CLK_BIT]       = card_clk_run;
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         SEL_STATUS: reg_rdata = status_word;
         SEL_ENABLE: reg_rdata[FLAG_W-1:0] = enable_q;
         default:    reg_rdata = '0;
      endcase
   end

   p_buf_bits_ignore_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && !buf_rd && !buf_wr) |=> (buf_flags & $past(buf_flags)) == $past(buf_flags));
   p_enable_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_enable |=> enable_q == $past(reg_wdata[FLAG_W-1:0]));
endmodule

// File: tb/host_int_status_test.sv
module host_int_status_test;
   localparam int DW = 32;
   localparam int NE = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = 2'd0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [NE-1:0] evt_pulse = '0;
   logic          rbuf_ready = 1'b0, wbuf_ready = 1'b0;
   logic          buf_rd = 1'b0, buf_wr = 1'b0;
   logic          card_clk_run = 1'b0;
   logic          irq;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   host_int_status #(.DATA_W(DW), .NUM_EVT(NE)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
      .rbuf_ready(rbuf_ready), .wbuf_ready(wbuf_ready), .buf_rd(buf_rd),
      .buf_wr(buf_wr), .card_clk_run(card_clk_run), .irq(irq)
   );

   // {wr, addr[1:0], wdata[10:0], evt[7:0], rset, wset, brd, bwr, exp_status[10:0], exp_irq}
   localparam int NV = 19;
   localparam logic [37:0] VEC [NV] = '{
      {1'b0, 2'd0, 11'h000, 8'h01, 4'b0000, 11'h004, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h80, 4'b0000, 11'h204, 1'b0},
      {1'b1, 2'd1, 11'h004, 8'h00, 4'b0000, 11'h204, 1'b1},
      {1'b1, 2'd0, 11'h004, 8'h00, 4'b0000, 11'h200, 1'b0},
      {1'b1, 2'd0, 11'h000, 8'h00, 4'b0000, 11'h200, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b1000, 11'h201, 1'b0},
      {1'b1, 2'd0, 11'h003, 8'h00, 4'b0000, 11'h201, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b0010, 11'h200, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b0100, 11'h202, 1'b0},
      {1'b1, 2'd0, 11'h002, 8'h00, 4'b0000, 11'h202, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b0001, 11'h200, 1'b0},
      {1'b1, 2'd1, 11'h3FF, 8'h00, 4'b0000, 11'h200, 1'b1},
      {1'b1, 2'd0, 11'h200, 8'h00, 4'b0000, 11'h000, 1'b0},
      {1'b1, 2'd0, 11'h004, 8'h01, 4'b0000, 11'h004, 1'b1},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b1010, 11'h005, 1'b1},
      {1'b1, 2'd0, 11'h7FF, 8'h00, 4'b0000, 11'h001, 1'b1},
      {1'b0, 2'd0, 11'h000, 8'h00, 4'b0010, 11'h000, 1'b0},
      {1'b1, 2'd2, 11'h3FF, 8'h00, 4'b0000, 11'h000, 1'b0},
      {1'b0, 2'd0, 11'h000, 8'h02, 4'b0000, 11'h008, 1'b1}
   };
   localparam string VTAG [NV] = '{
      "R2", "R2", "R8", "R3", "R3", "R5", "R5", "R6", "R5", "R5",
      "R6", "R8", "R3", "R4", "R6", "R3", "R6", "R10", "R2"
   };

   task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; evt_pulse = '0;
      rbuf_ready = 1'b0; wbuf_ready = 1'b0; buf_rd = 1'b0; buf_wr = 1'b0;
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      idle_inputs();
   endtask

   task automatic read_at(input logic [1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd;
      idle_inputs();
      repeat (3) @(negedge clk);
      // R1: reset state
      read_at(2'd0, rd); check("R1 status", rd, '0);
      read_at(2'd1, rd); check("R1 enable", rd, '0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         reg_wr     = VEC[v][37];
         reg_addr   = VEC[v][36:35];
         reg_wdata  = {21'd0, VEC[v][34:24]};
         evt_pulse  = VEC[v][23:16];
         rbuf_ready = VEC[v][15];
         wbuf_ready = VEC[v][14];
         buf_rd     = VEC[v][13];
         buf_wr     = VEC[v][12];
         @(negedge clk);
         idle_inputs();
         @(negedge clk);
         read_at(2'd0, rd);
         check(VTAG[v], rd, {21'd0, VEC[v][11:1]});
         check({VTAG[v], " irq"}, {31'd0, irq}, {31'd0, VEC[v][0]});
      end

      // R8: irq drops one edge after the flag clears (status 0x008 enabled, irq high)
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h008;
      @(negedge clk);
      idle_inputs();
      read_at(2'd0, rd); check("R8 flag cleared", rd, 32'h0);
      check("R8 irq still high", {31'd0, irq}, 32'd1);
      @(negedge clk);
      check("R8 irq low", {31'd0, irq}, 32'd0);

      // R7: enable bit for the clock-running position does not store
      reg_write(2'd1, 32'hFFFF_FFFF);
      read_at(2'd1, rd); check("R7 enable readback", rd, 32'h3FF);

      // R9: live clock-running bit, write ignored
      card_clk_run = 1'b1;
      read_at(2'd0, rd); check("R9 clk run high", rd, 32'h400);
      reg_write(2'd0, 32'h400);
      read_at(2'd0, rd); check("R9 write ignored", rd, 32'h400);
      check("R9 no irq", {31'd0, irq}, 32'd0);
      card_clk_run = 1'b0;
      read_at(2'd0, rd); check("R9 clk run low", rd, 32'h0);

      // R10: spare address reads zero
      read_at(2'd3, rd); check("R10 spare read", rd, 32'h0);

      // R1: reset mid-run clears flags, enables and irq
      @(negedge clk);
      evt_pulse = 8'h10; rbuf_ready = 1'b1;
      @(negedge clk);
      idle_inputs();
      @(negedge clk);
      check("R1 pre-reset irq", {31'd0, irq}, 32'd1);
      rst_n = 1'b0;
      #1;
      read_at(2'd0, rd); check("R1 status after reset", rd, 32'h0);
      read_at(2'd1, rd); check("R1 enable after reset", rd, 32'h0);
      check("R1 irq after reset", {31'd0, irq}, 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule